// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer with a small word-addressed register set. Software drives it entirely through key codes written to one key register. One code starts the counter, another restarts the current period, and a third opens the configuration registers for writing, which a fourth closes again. Once started, the timer cannot be stopped by any write. Only a reset of the block returns it to the idle state.

The counter side runs from a slow timebase, given here as a one-cycle enable `lsi_tick` in the bus clock. A power-of-two prescaler divides those ticks. Each prescaler overflow decrements a 12-bit counter. When the counter is exhausted, the block raises `wdt_reset_req` for exactly one bus clock and starts a new period from the reload value. New prescaler and reload values are written into shadow registers. A busy flag stays set until the next slow tick copies each value into the counter side.

An optional early-warning interrupt latches when the counter steps onto a programmed compare value. It stays set until software writes a one to its acknowledge bit.

The counter is controlled by a three-state machine:
- `ST_STOPPED` is the state after reset. A start key takes it to `ST_COUNTING` (transition *arm*).
- `ST_COUNTING` holds while the counter runs. A refresh key reloads the counter and keeps this state (transition *kick*). An exhausted counter moves it to `ST_FIRE` (transition *expire*).
- `ST_FIRE` lasts one clock. It drives the reset request, reloads the counter and returns to `ST_COUNTING` (transition *rearm*).

Top module: `iwdt_top`

## Requirements
- R1: After reset the block is stopped, both outputs are low, and the registers read as follows: prescaler 0, reload 0xFFF, status 0, early-control 0.
- R2: Writes to the prescaler (offset 0x04), the reload (0x08) and the compare/enable fields of early-control (0x14) take effect only while unlocked. Key 0x5555 at offset 0x00 unlocks. Key 0x0000 locks again. Reset leaves the block locked.
- R3: Status (0x0C) bit 0 is set by an accepted prescaler write and bit 1 by an accepted reload write. Each bit clears on the first slow tick that arrives with no new write to its register in the same cycle.
- R4: Key 0xCCCC starts the timer. Exactly (reload+1) × 2^(prescaler+2) slow ticks after the start write, `wdt_reset_req` goes high for one clock.
- R5: Prescaler field values of 8 and above all select the largest divider, 1024.
- R6: Key 0xAAAA written while running restarts the full period, including the prescaler phase.
- R7: No key write stops a running timer. Keys 0x0000, 0x5555 and unknown codes leave the countdown running.
- R8: With early-control bit 15 set and compare value C in bits 11:0 (C < reload), `wdt_early_irq` rises (reload−C) × divider slow ticks after start and stays high until acknowledged.
- R9: Writing 1 to early-control bit 14 clears the pending interrupt whether or not the block is unlocked. Reading bit 14 returns the pending flag.
- R10: After a reset request the counter reloads and the next request follows one full period later. A slow tick during the one `ST_FIRE` clock is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lsi_tick | input | 1 | One-cycle enable marking each slow-timebase tick |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_reset_req | output | 1 | One-clock reset request on expiry |
| wdt_early_irq | output | 1 | Latched early-warning interrupt |

## Verification
A wrong divider or reload copy makes the measured tick count to the reset request miss its expected product. The error shows in the first period after start. A stuck busy flag or a lock leak appears in the next readback of status or of the shadowed register. A machine that could stop, or that holds `ST_FIRE` too long, shows as a missing or widened request pulse within one period. A compare error moves the interrupt edge by whole prescaler periods.

// File: rtl/iwdt_pkg.sv
package iwdt_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CNT_W   = 12;
    localparam int PR_W    = 4;
    localparam int PR_BASE = 2;
    localparam int PR_CAP  = 8;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 32;

    localparam logic [15:0] KEY_START  = 16'hCCCC;
    localparam logic [15:0] KEY_KICK   = 16'hAAAA;
    localparam logic [15:0] KEY_OPEN   = 16'h5555;
    localparam logic [15:0] KEY_CLOSE  = 16'h0000;

    localparam int OFS_KEY = 'h00;
    localparam int OFS_PR  = 'h04;
    localparam int OFS_RLD = 'h08;
    localparam int OFS_SR  = 'h0C;
    localparam int OFS_EW  = 'h14;

    localparam int EW_ACK_BIT = 14;
    localparam int EW_EN_BIT  = 15;

    typedef enum logic [1:0] {
        ST_STOPPED  = 2'd0,
        ST_COUNTING = 2'd1,
        ST_FIRE     = 2'd2
    } wd_state_e;
endpackage

// File: rtl/iwdt_regs.sv
module iwdt_regs
    import iwdt_pkg::*;
#(
    parameter int P_CNT_W  = CNT_W,
    parameter int P_PR_W   = PR_W,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_DATA_W = DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lsi_tick,
    input  logic                bus_we,
    input  logic [P_ADDR_W-1:0] bus_addr,
    input  logic [P_DATA_W-1:0] bus_wdata,
    input  logic                irq_pend,
    output logic [P_DATA_W-1:0] bus_rdata,
    output logic                key_start,
    output logic                key_kick,
    output logic [P_PR_W-1:0]   pr_act,
    output logic [P_CNT_W-1:0]  rld_act,
    output logic [P_CNT_W-1:0]  cmp_val,
    output logic                irq_en,
    output logic                ack_wr
);
    timeunit 1ns;
    timeprecision 100ps;

    logic                unlocked;
    logic [P_PR_W-1:0]   pr_sh;
    logic [P_CNT_W-1:0]  rld_sh;
    logic                pr_busy;
    logic                rld_busy;
    logic [15:0]         key_val;
    logic                wr_key, wr_pr, wr_rld, wr_ew;
    logic                unused_hi;

    assign key_val   = bus_wdata[15:0];
    assign unused_hi = &{1'b0, bus_wdata[P_DATA_W-1:16]};
    assign wr_key    = bus_we && (bus_addr == P_ADDR_W'(OFS_KEY));
    assign wr_pr     = bus_we && unlocked && (bus_addr == P_ADDR_W'(OFS_PR));
    assign wr_rld    = bus_we && unlocked && (bus_addr == P_ADDR_W'(OFS_RLD));
    assign wr_ew     = bus_we && unlocked && (bus_addr == P_ADDR_W'(OFS_EW));
    assign ack_wr    = bus_we && (bus_addr == P_ADDR_W'(OFS_EW)) && bus_wdata[EW_ACK_BIT];
    assign key_start = wr_key && (key_val == KEY_START);
    assign key_kick  = wr_key && (key_val == KEY_KICK);

    // lock state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
        end else if (wr_key) begin
            if (key_val == KEY_OPEN)
                unlocked <= 1'b1;
            else if (key_val == KEY_CLOSE)
                unlocked <= 1'b0;
        end
    end

    // prescaler shadow and transfer into the counter side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pr_sh   <= '0;
            pr_act  <= '0;
            pr_busy <= 1'b0;
        end else if (wr_pr) begin
            pr_sh   <= bus_wdata[P_PR_W-1:0];
            pr_busy <= 1'b1;
        end else if (pr_busy && lsi_tick) begin
            pr_act  <= pr_sh;
            pr_busy <= 1'b0;
        end
    end

    // reload shadow and transfer into the counter side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rld_sh   <= '1;
            rld_act  <= '1;
            rld_busy <= 1'b0;
        end else if (wr_rld) begin
            rld_sh   <= bus_wdata[P_CNT_W-1:0];
            rld_busy <= 1'b1;
        end else if (rld_busy && lsi_tick) begin
            rld_act  <= rld_sh;
            rld_busy <= 1'b0;
        end
    end

    // early-warning compare and enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_val <= '0;
            irq_en  <= 1'b0;
        end else if (wr_ew) begin
            cmp_val <= bus_wdata[P_CNT_W-1:0];
            irq_en  <= bus_wdata[EW_EN_BIT];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            P_ADDR_W'(OFS_PR):  bus_rdata[P_PR_W-1:0]  = pr_sh;
            P_ADDR_W'(OFS_RLD): bus_rdata[P_CNT_W-1:0] = rld_sh;
            P_ADDR_W'(OFS_SR):  bus_rdata[1:0]         = {rld_busy, pr_busy};
            P_ADDR_W'(OFS_EW): begin
                bus_rdata[P_CNT_W-1:0] = cmp_val;
                bus_rdata[EW_ACK_BIT]  = irq_pend;
                bus_rdata[EW_EN_BIT]   = irq_en;
            end
            default: bus_rdata = '0;
        endcase
    end

    a_r2_locked_pr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !unlocked && bus_addr == P_ADDR_W'(OFS_PR)) |=> $stable(pr_sh));

    a_r2_locked_rld_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !unlocked && bus_addr == P_ADDR_W'(OFS_RLD)) |=> $stable(rld_sh));

    a_r3_pr_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_busy && lsi_tick && !wr_pr) |=> (!pr_busy && pr_act == $past(pr_sh)));

    a_r3_rld_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_busy && lsi_tick && !wr_rld) |=> (!rld_busy && rld_act == $past(rld_sh)));
endmodule

// File: rtl/iwdt_core.sv
module iwdt_core
    import iwdt_pkg::*;
#(
    parameter int P_CNT_W   = CNT_W,
    parameter int P_PR_W    = PR_W,
    parameter int P_PR_BASE = PR_BASE,
    parameter int P_PR_CAP  = PR_CAP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lsi_tick,
    input  logic               key_start,
    input  logic               key_kick,
    input  logic [P_PR_W-1:0]  pr_act,
    input  logic [P_CNT_W-1:0] rld_act,
    output logic [P_CNT_W-1:0] cnt,
    output logic               pres_tick,
    output logic               rst_req
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int PS_W = P_PR_BASE + P_PR_CAP;

    wd_state_e         state, state_nx;
    logic [PS_W-1:0]   ps_cnt;
    logic [PS_W-1:0]   ps_last;
    logic [PS_W:0]     span;
    logic [P_PR_W-1:0] pr_eff;
    logic              reload_now;

    // prescaler divider, clamped at the largest setting
    always_comb begin
        pr_eff  = (pr_act > P_PR_W'(P_PR_CAP)) ? P_PR_W'(P_PR_CAP) : pr_act;
        span    = (PS_W+1)'(1) << (P_PR_BASE + int'(pr_eff));
        ps_last = PS_W'(span - (PS_W+1)'(1));
    end

    assign pres_tick = (state == ST_COUNTING) && lsi_tick && (ps_cnt == ps_last);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_STOPPED;
        else
            state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STOPPED:  if (key_start) state_nx = ST_COUNTING;
            ST_COUNTING: if (pres_tick && cnt == '0 && !key_kick) state_nx = ST_FIRE;
            ST_FIRE:     state_nx = ST_COUNTING;
            default:     state_nx = ST_STOPPED;
        endcase
    end

    assign reload_now = (state == ST_STOPPED && key_start) ||
                        (state == ST_COUNTING && key_kick) ||
                        (state == ST_FIRE);

    // counter and prescaler datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '1;
            ps_cnt <= '0;
        end else if (reload_now) begin
            cnt    <= rld_act;
            ps_cnt <= '0;
        end else if (state == ST_COUNTING && lsi_tick) begin
            if (ps_cnt == ps_last) begin
                ps_cnt <= '0;
                if (cnt != '0)
                    cnt <= cnt - P_CNT_W'(1);
            end else begin
                ps_cnt <= ps_cnt + PS_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        rst_req = (state == ST_FIRE);
    end

    a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    a_r7_never_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_STOPPED) |=> (state != ST_STOPPED));

    a_r10_reload_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIRE) |=> (cnt == $past(rld_act) && state == ST_COUNTING));

    a_r6_kick_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNTING && key_kick) |=> (cnt == $past(rld_act) && ps_cnt == '0));
endmodule

// File: rtl/iwdt_early.sv
module iwdt_early
    import iwdt_pkg::*;
#(
    parameter int P_CNT_W = CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pres_tick,
    input  logic [P_CNT_W-1:0] cnt,
    input  logic [P_CNT_W-1:0] cmp_val,
    input  logic               irq_en,
    input  logic               ack_wr,
    output logic               irq
);
    timeunit 1ns;
    timeprecision 100ps;

    logic hit;

    // the counter is about to step onto the compare value
    assign hit = pres_tick && irq_en && (cnt != '0) && ((cnt - P_CNT_W'(1)) == cmp_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (hit)
            irq <= 1'b1;
        else if (ack_wr)
            irq <= 1'b0;
    end

    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !hit) |=> !irq);

    a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_wr) |=> irq);

    a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !irq_en) |=> !irq);
endmodule

// File: rtl/iwdt_top.sv
module iwdt_top
    import iwdt_pkg::*;
#(
    parameter int P_CNT_W   = CNT_W,
    parameter int P_PR_W    = PR_W,
    parameter int P_PR_BASE = PR_BASE,
    parameter int P_PR_CAP  = PR_CAP,
    parameter int P_ADDR_W  = ADDR_W,
    parameter int P_DATA_W  = DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lsi_tick,
    input  logic                bus_we,
    input  logic [P_ADDR_W-1:0] bus_addr,
    input  logic [P_DATA_W-1:0] bus_wdata,
    output logic [P_DATA_W-1:0] bus_rdata,
    output logic                wdt_reset_req,
    output logic                wdt_early_irq
);
    timeunit 1ns;
    timeprecision 100ps;

    logic               key_start, key_kick, ack_wr, irq_en, pres_tick;
    logic [P_PR_W-1:0]  pr_act;
    logic [P_CNT_W-1:0] rld_act, cmp_val, cnt;

    iwdt_regs #(
        .P_CNT_W(P_CNT_W), .P_PR_W(P_PR_W), .P_ADDR_W(P_ADDR_W), .P_DATA_W(P_DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .lsi_tick(lsi_tick),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .irq_pend(wdt_early_irq), .bus_rdata(bus_rdata),
        .key_start(key_start), .key_kick(key_kick),
        .pr_act(pr_act), .rld_act(rld_act),
        .cmp_val(cmp_val), .irq_en(irq_en), .ack_wr(ack_wr)
    );

    iwdt_core #(
        .P_CNT_W(P_CNT_W), .P_PR_W(P_PR_W), .P_PR_BASE(P_PR_BASE), .P_PR_CAP(P_PR_CAP)
    ) u_core (
        .clk(clk), .rst_n(rst_n), .lsi_tick(lsi_tick),
        .key_start(key_start), .key_kick(key_kick),
        .pr_act(pr_act), .rld_act(rld_act),
        .cnt(cnt), .pres_tick(pres_tick), .rst_req(wdt_reset_req)
    );

    iwdt_early #(
        .P_CNT_W(P_CNT_W)
    ) u_early (
        .clk(clk), .rst_n(rst_n), .pres_tick(pres_tick), .cnt(cnt),
        .cmp_val(cmp_val), .irq_en(irq_en), .ack_wr(ack_wr), .irq(wdt_early_irq)
    );
endmodule

// File: tb/iwdt_top_bench.sv
module iwdt_top_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lsi_tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_reset_req;
    logic        wdt_early_irq;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    iwdt_top u_iwdt_top (
        .clk(clk), .rst_n(rst_n), .lsi_tick(lsi_tick),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdt_reset_req(wdt_reset_req), .wdt_early_irq(wdt_early_irq)
    );

    function automatic int divider(input int pr);
        return 1 << (2 + ((pr > 8) ? 8 : pr));
    endfunction

    function automatic int exp_timeout(input int rld, input int pr);
        return (rld + 1) * divider(pr);
    endfunction

    function automatic int exp_early(input int rld, input int cmp, input int pr);
        return (rld - cmp) * divider(pr);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // every task starts and ends just after a falling edge
    task automatic do_reset();
        rst_n = 1'b0; lsi_tick = 1'b0; bus_we = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input int data);
        bus_we = 1'b1; bus_addr = 5'(addr); bus_wdata = 32'(data); lsi_tick = 1'b0;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int addr, output int data);
        bus_addr = 5'(addr);
        #1;
        data = int'(bus_rdata);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            lsi_tick = 1'b1;
            @(negedge clk);
        end
        lsi_tick = 1'b0;
    endtask

    // counts slow ticks until the chosen output is high
    task automatic measure(input bit use_irq, input bit sparse, output int n);
        int loops;
        n = 0;
        loops = 0;
        while (!(use_irq ? wdt_early_irq : wdt_reset_req)) begin
            lsi_tick = sparse ? 1'($urandom % 2) : 1'b1;
            if (lsi_tick) n++;
            loops++;
            if (loops > 20000) begin
                n = -1;
                break;
            end
            @(negedge clk);
        end
        lsi_tick = 1'b0;
    endtask

    task automatic configure(input int pr, input int rld);
        int sr;
        wr('h00, 'h5555);
        wr('h04, pr);
        wr('h08, rld);
        tick_n(1);
        rd('h0C, sr);
        chk("R3 busy cleared after tick", sr, 0);
        wr('h00, 'h0000);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        int v, n;
        void'($urandom(32'd20240));
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 reset_req low", int'(wdt_reset_req), 0);
        chk("R1 irq low", int'(wdt_early_irq), 0);
        rd('h04, v); chk("R1 prescaler", v, 0);
        rd('h08, v); chk("R1 reload", v, 'hFFF);
        rd('h0C, v); chk("R1 status", v, 0);
        rd('h14, v); chk("R1 early ctrl", v, 0);

        // R2 lock, R3 busy flags
        wr('h04, 3);
        rd('h04, v); chk("R2 locked prescaler write ignored", v, 0);
        rd('h0C, v); chk("R2 locked write sets no busy", v, 0);
        wr('h00, 'h5555);
        wr('h04, 3);
        rd('h0C, v); chk("R3 prescaler busy bit0", v, 1);
        rd('h04, v); chk("R2 unlocked prescaler write", v, 3);
        wr('h08, 5);
        rd('h0C, v); chk("R3 both busy bits", v, 3);
        tick_n(1);
        rd('h0C, v); chk("R3 busy clears on tick", v, 0);
        wr('h00, 'h0000);
        wr('h08, 9);
        rd('h08, v); chk("R2 relocked reload write ignored", v, 5);

        // R4 start and timeout, R10 periodic reload
        configure(0, 5);
        wr('h00, 'hCCCC);
        measure(1'b0, 1'b0, n); chk("R4 timeout ticks", n, exp_timeout(5, 0));
        @(negedge clk);
        chk("R4 request lasts one clock", int'(wdt_reset_req), 0);
        measure(1'b0, 1'b1, n); chk("R10 second period ticks", n, exp_timeout(5, 0));

        // R7 no key stops it
        do_reset();
        configure(1, 3);
        wr('h00, 'hCCCC);
        wr('h00, 'h0000);
        wr('h00, 'h5555);
        wr('h00, 'h1234);
        wr('h00, 'h0000);
        measure(1'b0, 1'b1, n); chk("R7 still expires after other keys", n, exp_timeout(3, 1));

        // R6 refresh restarts the full period
        do_reset();
        configure(1, 4);
        wr('h00, 'hCCCC);
        tick_n(17);
        chk("R6 no request before refresh", int'(wdt_reset_req), 0);
        wr('h00, 'hAAAA);
        measure(1'b0, 1'b0, n); chk("R6 full period after refresh", n, exp_timeout(4, 1));

        // R5 clamped divider
        do_reset();
        configure(15, 1);
        rd('h04, v); chk("R5 field stored as written", v, 15);
        wr('h00, 'hCCCC);
        measure(1'b0, 1'b0, n); chk("R5 divider clamps at 1024", n, exp_timeout(1, 15));

        // R8 early interrupt, R9 acknowledge
        do_reset();
        wr('h00, 'h5555);
        wr('h14, 'h8006);
        configure(0, 10);
        wr('h00, 'hCCCC);
        measure(1'b1, 1'b1, n); chk("R8 early irq ticks", n, exp_early(10, 6, 0));
        rd('h14, v); chk("R9 pending readable", (v >> 14) & 1, 1);
        tick_n(3);
        chk("R8 irq held", int'(wdt_early_irq), 1);
        wr('h14, 'h4000);
        chk("R9 ack clears while locked", int'(wdt_early_irq), 0);
        rd('h14, v); chk("R2 locked ack keeps compare and enable", v, 'h8006);

        // R4 randomized configurations
        for (int it = 0; it < 6; it++) begin
            int r, p;
            r = 2 + int'($urandom % 11);
            p = int'($urandom % 3);
            do_reset();
            configure(p, r);
            wr('h00, 'hCCCC);
            measure(1'b0, 1'b1, n);
            chk("R4 random timeout", n, exp_timeout(r, p));
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule